// File: doc/BRIEF.md
# SDRAM Initialization Command Controller

This block sits inside a memory bus controller and turns processor writes into the commands that bring an SDRAM out of power-up. Two address windows are decoded, one per SDRAM area. A byte write into either window produces one command on that area's chip select. A control input decides which command it is. With the input at 0 the write issues a precharge of all banks. With it at 1 the write issues a mode-register load. The mode word comes from the write's offset inside the window, and no write data path exists at all.

Software runs a fixed sequence. It waits for the power-up idle window to end, writes once to precharge, then lets at least eight auto-refresh commands run, and finally writes the mode offset. The block makes the auto-refresh commands itself from an interval timer. A fast-interval input shortens the gap while the dummy refreshes run. A flag reports when enough refreshes have gone by since the last precharge. After any command the write port holds ready low for a set recovery time.

Top module: `sdram_init_cmd_ctrl`

## Requirements
- R1: While reset is held, both chip selects are high and RAS, CAS and WE are high (no operation). `req_ready`, `idle_done` and `dummy_ref_done` are low.
- R2: `req_ready` stays low and `idle_done` stays 0 for the first IDLE_CYCLES clock edges after reset release. `idle_done` becomes 1 on edge IDLE_CYCLES and stays 1.
- R3: An accepted byte write (`req_size`=0) to the area-2 window (0xFF900000..0xFF93FFFF) or the area-3 window (0xFF940000..0xFF97FFFF) with `mrs_sel`=0 drives a precharge-all for exactly one cycle, starting the cycle after acceptance. In that cycle RAS=0, CAS=1, WE=0, `sd_addr` has only bit 10 set, and `sd_cs_n` is 2'b10 for area 2 or 2'b01 for area 3 (bit 0 is area 2).
- R4: With `mrs_sel`=1 and `bus_wide`=0, the same write drives a mode-register load instead. In that cycle RAS=0, CAS=0, WE=0, the chip select is as in R3, and `sd_addr` = (window offset / 4) modulo 2^ADDR_W. For example, offset 0x88 loads 0x22 and offset 0xCC loads 0x33.
- R5: With `mrs_sel`=1 and `bus_wide`=1, `sd_addr` = (window offset / 8) modulo 2^ADDR_W. For example, offset 0x110 loads 0x22.
- R6: A write outside both windows, or a window write with `req_size` other than 0, is accepted but issues no command. The SDRAM pins stay idle and `req_ready` stays high on the following cycle.
- R7: After a command is issued, `req_ready` is low for exactly RECOV_CYC cycles.
- R8: While `ref_en`=1, the block issues an auto-refresh every REF_NORMAL cycles, or every REF_FAST cycles when `ref_fast`=1. An auto-refresh drives both chip selects low with RAS=0, CAS=0, WE=1 for one cycle.
- R9: `dummy_ref_done` rises in the cycle the DUMMY_REF-th auto-refresh after the last precharge-all appears. A precharge-all clears it.
- R10: Every command lasts one cycle and is followed by a no-operation cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor write request |
| req_ready | output | 1 | Write accepted on this edge when valid |
| req_addr | input | 32 | Write byte address |
| req_size | input | 2 | Access size, 0 = byte |
| mrs_sel | input | 1 | 0: precharge-all, 1: mode-register load |
| bus_wide | input | 1 | 1: 64-bit data bus (offset / 8), 0: 32-bit (offset / 4) |
| ref_en | input | 1 | Enable the auto-refresh timer |
| ref_fast | input | 1 | Use the short refresh interval |
| sd_cs_n | output | 2 | Chip selects, bit 0 area 2, bit 1 area 3 |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_addr | output | ADDR_W | SDRAM address lines |
| idle_done | output | 1 | Power-up idle window has elapsed |
| dummy_ref_done | output | 1 | Enough refreshes since last precharge-all |

## Verification
The bench uses the nine legal mode offsets on both areas and both bus widths. A design that shifted by the wrong amount or drove the wrong chip select would load a wrong mode word or hit the other SDRAM. It sends half-word and word writes into the windows and byte writes just outside them. A design with a loose decode would issue a stray precharge or mode load. It counts the cycles ready stays low after each command, and the exact spacing between refreshes at both intervals, which exposes off-by-one errors in the recovery and interval counters. It checks the refresh flag right after the seventh and the eighth refresh and again after a later precharge. A wrong threshold, or a count that a precharge does not clear, shows up there.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  localparam logic [1:0] SZ_BYTE = 2'd0;

  typedef struct packed {
    logic [1:0] cs_n;
    logic       ras_n;
    logic       cas_n;
    logic       we_n;
  } sd_ctl_t;

  localparam sd_ctl_t CTL_NOP = '{cs_n: 2'b11, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

  // mode word carried on the address pins: offset scaled by bus width
  function automatic logic [31:0] mode_word(input logic [31:0] off, input logic wide);
    return wide ? (off >> 3) : (off >> 2);
  endfunction

  // active-low select for one area (bit 0 = area 2)
  function automatic logic [1:0] area_sel(input logic area3);
    return area3 ? 2'b01 : 2'b10;
  endfunction

endpackage

// File: rtl/sdram_win_decode.sv
module sdram_win_decode #(
  parameter int          WIN_BITS  = 18,
  parameter logic [31:0] WIN2_BASE = 32'hFF90_0000,
  parameter logic [31:0] WIN3_BASE = 32'hFF94_0000
) (
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  output logic        hit,
  output logic        area3,
  output logic        is_byte,
  output logic [31:0] offset
);
  import sdram_cmd_pkg::*;

  localparam int TAG_W = 32 - WIN_BITS;

  logic hit2, hit3;

  assign hit2    = addr[31:WIN_BITS] == WIN2_BASE[31:WIN_BITS];
  assign hit3    = addr[31:WIN_BITS] == WIN3_BASE[31:WIN_BITS];
  assign hit     = hit2 | hit3;
  assign area3   = hit3;
  assign is_byte = size == SZ_BYTE;
  assign offset  = {{TAG_W{1'b0}}, addr[WIN_BITS-1:0]};

  always_comb begin
    assert (!(hit2 && hit3)) else $error("AST_WINDOWS_DISJOINT"); // R3
  end
endmodule

// File: rtl/sdram_pwr_timer.sv
module sdram_pwr_timer #(
  parameter int IDLE_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic idle_done
);
  localparam int CNT_W = $clog2(IDLE_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt <= '0;
    else if (cnt != CNT_W'(IDLE_CYCLES)) cnt <= cnt + 1'b1;
  end

  assign idle_done = cnt == CNT_W'(IDLE_CYCLES);

  AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    idle_done |=> idle_done); // R2
endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int REF_NORMAL = 780,
  parameter int REF_FAST   = 8,
  parameter int DUMMY_REF  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  input  logic ref_issue,
  input  logic pall_issue,
  output logic ref_pend,
  output logic dummy_done
);
  localparam int TW = $clog2(REF_NORMAL + REF_FAST + 1);
  localparam int DW = $clog2(DUMMY_REF + 1);

  logic [TW-1:0] tmr, ival;
  logic [DW-1:0] nref;
  logic          tick;

  assign ival = fast ? TW'(REF_FAST) : TW'(REF_NORMAL);
  assign tick = run && (tmr >= ival - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr      <= '0;
      ref_pend <= 1'b0;
    end else begin
      if (!run)      tmr <= '0;
      else if (tick) tmr <= '0;
      else           tmr <= tmr + 1'b1;
      if (tick)           ref_pend <= 1'b1;
      else if (ref_issue) ref_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                      nref <= '0;
    else if (pall_issue)                             nref <= '0;
    else if (ref_issue && nref != DW'(DUMMY_REF))    nref <= nref + 1'b1;
  end

  assign dummy_done = nref == DW'(DUMMY_REF);

  AST_REF_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    nref <= DW'(DUMMY_REF)); // R9
  AST_PALL_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pall_issue |=> !dummy_done); // R9
endmodule

// File: rtl/sdram_init_cmd_ctrl.sv
module sdram_init_cmd_ctrl #(
  parameter int          ADDR_W      = 14,
  parameter int          WIN_BITS    = 18,
  parameter logic [31:0] WIN2_BASE   = 32'hFF90_0000,
  parameter logic [31:0] WIN3_BASE   = 32'hFF94_0000,
  parameter int          IDLE_CYCLES = 10000,
  parameter int          REF_NORMAL  = 780,
  parameter int          REF_FAST    = 8,
  parameter int          RECOV_CYC   = 3,
  parameter int          DUMMY_REF   = 8,
  parameter int          AP_BIT      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [1:0]        req_size,
  input  logic              mrs_sel,
  input  logic              bus_wide,
  input  logic              ref_en,
  input  logic              ref_fast,
  output logic [1:0]        sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              idle_done,
  output logic              dummy_ref_done
);
  import sdram_cmd_pkg::*;

  localparam int BUSY_W = $clog2(RECOV_CYC + 1);
  localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << AP_BIT;

  logic              hit, area3, is_byte;
  logic [31:0]       offset;
  logic [BUSY_W-1:0] busy;
  logic              ref_pend;
  sd_ctl_t           ctl_q;
  logic [ADDR_W-1:0] addr_q;

  // named events for the assertions
  logic win_accept, ignored_accept, pall_issue, mrs_issue, ref_issue;

  sdram_win_decode #(.WIN_BITS(WIN_BITS), .WIN2_BASE(WIN2_BASE), .WIN3_BASE(WIN3_BASE)) u_dec (
    .addr(req_addr), .size(req_size), .hit(hit), .area3(area3),
    .is_byte(is_byte), .offset(offset)
  );

  sdram_pwr_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_pwr (
    .clk(clk), .rst_n(rst_n), .idle_done(idle_done)
  );

  sdram_ref_timer #(.REF_NORMAL(REF_NORMAL), .REF_FAST(REF_FAST), .DUMMY_REF(DUMMY_REF)) u_ref (
    .clk(clk), .rst_n(rst_n), .run(ref_en && idle_done), .fast(ref_fast),
    .ref_issue(ref_issue), .pall_issue(pall_issue),
    .ref_pend(ref_pend), .dummy_done(dummy_ref_done)
  );

  assign req_ready      = idle_done && busy == '0 && !ref_pend;
  assign win_accept     = req_valid && req_ready && hit && is_byte;
  assign ignored_accept = req_valid && req_ready && !(hit && is_byte);
  assign pall_issue     = win_accept && !mrs_sel;
  assign mrs_issue      = win_accept && mrs_sel;
  assign ref_issue      = ref_pend && idle_done && busy == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= CTL_NOP;
      addr_q <= '0;
      busy   <= '0;
    end else begin
      ctl_q  <= CTL_NOP;
      addr_q <= '0;
      if (busy != '0) busy <= busy - 1'b1;
      if (win_accept) begin
        ctl_q  <= '{cs_n: area_sel(area3), ras_n: 1'b0, cas_n: !mrs_sel, we_n: 1'b0};
        addr_q <= mrs_sel ? ADDR_W'(mode_word(offset, bus_wide)) : PALL_ADDR;
        busy   <= BUSY_W'(RECOV_CYC);
      end else if (ref_issue) begin
        ctl_q  <= '{cs_n: 2'b00, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
        busy   <= BUSY_W'(RECOV_CYC);
      end
    end
  end

  assign sd_cs_n  = ctl_q.cs_n;
  assign sd_ras_n = ctl_q.ras_n;
  assign sd_cas_n = ctl_q.cas_n;
  assign sd_we_n  = ctl_q.we_n;
  assign sd_addr  = addr_q;

  AST_NO_READY_BEFORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_done |-> !req_ready); // R2
  AST_PALL_ENCODE: assert property (@(posedge clk) disable iff (!rst_n)
    pall_issue |=> (!sd_ras_n && sd_cas_n && !sd_we_n && sd_addr[AP_BIT])); // R3
  AST_MRS_ENCODE: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_issue |=> (!sd_ras_n && !sd_cas_n && !sd_we_n && $countones(sd_cs_n) == 1)); // R4
  AST_IGNORED_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_accept |=> (sd_cs_n == 2'b11 && req_ready)); // R6
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (win_accept || ref_issue) |=> !req_ready); // R7
  AST_REF_BOTH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_issue |=> (sd_cs_n == 2'b00 && !sd_ras_n && !sd_cas_n && sd_we_n)); // R8
  AST_CMD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cs_n != 2'b11) |=> (sd_cs_n == 2'b11)); // R10
endmodule

// File: tb/tb_sdram_init_cmd_ctrl.sv
module tb_sdram_init_cmd_ctrl;
  localparam int IDLE  = 300;
  localparam int RNORM = 40;
  localparam int RFAST = 8;
  localparam int RECOV = 3;
  localparam logic [31:0] B2 = 32'hFF90_0000;
  localparam logic [31:0] B3 = 32'hFF94_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, mrs_sel = 1'b0, bus_wide = 1'b0, ref_en = 1'b0, ref_fast = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic req_ready, sd_ras_n, sd_cas_n, sd_we_n, idle_done, dummy_ref_done;
  logic [1:0]  sd_cs_n;
  logic [13:0] sd_addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sdram_init_cmd_ctrl #(.IDLE_CYCLES(IDLE), .REF_NORMAL(RNORM), .REF_FAST(RFAST),
                        .RECOV_CYC(RECOV)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .mrs_sel(mrs_sel), .bus_wide(bus_wide),
    .ref_en(ref_en), .ref_fast(ref_fast), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
    .idle_done(idle_done), .dummy_ref_done(dummy_ref_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected pins {cs_n, ras, cas, we, addr} from the requirement text
  function automatic logic [18:0] expect_pins(input logic [31:0] a, input logic [1:0] sz,
                                              input logic m, input logic w);
    logic in2, in3;
    logic [1:0] cs;
    logic [31:0] off, mw;
    in2 = (a >= B2) && (a < B3);
    in3 = (a >= B3) && (a < 32'hFF98_0000);
    if (sz != 2'd0 || !(in2 || in3)) return {2'b11, 3'b111, 14'd0};
    cs = in2 ? 2'b10 : 2'b01;
    if (!m) return {cs, 3'b010, 14'h0400};
    off = a - (in2 ? B2 : B3);
    mw  = w ? off / 8 : off / 4;
    return {cs, 3'b000, mw[13:0]};
  endfunction

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [31:0] a, input logic [1:0] sz,
                          input logic m, input logic w);
    logic [18:0] exp;
    string tag;
    int low;
    wait_ready();
    req_addr = a; req_size = sz; mrs_sel = m; bus_wide = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    exp = expect_pins(a, sz, m, w);
    if (exp[18:17] == 2'b11) tag = "R6";
    else if (!m)             tag = "R3";
    else                     tag = w ? "R5" : "R4";
    chk(tag, {13'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_addr}, {13'd0, exp});
    if (exp[18:17] == 2'b11) begin
      chk("R6 ready kept", {31'd0, req_ready}, 32'd1);
    end else begin
      low = 0;
      while (!req_ready && low < 20) begin
        low++;
        @(negedge clk);
        if (low == 1) chk("R10 nop after cmd", {30'd0, sd_cs_n}, 32'd3);
      end
      chk("R7 recovery", low, RECOV);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] offs32 [6];
    logic [31:0] offs64 [3];
    int seed, last, k, cyc;
    offs32 = '{32'h48, 32'h88, 32'hC8, 32'h4C, 32'h8C, 32'hCC};
    offs64 = '{32'h90, 32'h110, 32'h190};
    seed = $urandom(32'd1234);

    repeat (4) @(negedge clk);
    chk("R1 idle pins", {27'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h1F);
    chk("R1 flags", {29'd0, req_ready, idle_done, dummy_ref_done}, 32'd0);
    rst_n = 1'b1;
    repeat (IDLE - 1) @(negedge clk);
    chk("R2 still idle", {30'd0, req_ready, idle_done}, 32'd0);
    @(negedge clk);
    chk("R2 idle done", {30'd0, req_ready, idle_done}, 32'd3);

    do_write(B2 + 32'h48, 2'd0, 1'b0, 1'b0);          // R3 area 2
    do_write(B3 + 32'h1234, 2'd0, 1'b0, 1'b1);        // R3 area 3
    foreach (offs32[i]) begin
      do_write(B2 + offs32[i], 2'd0, 1'b1, 1'b0);     // R4
      do_write(B3 + offs32[i], 2'd0, 1'b1, 1'b0);
    end
    foreach (offs64[i]) begin
      do_write(B2 + offs64[i], 2'd0, 1'b1, 1'b1);     // R5
      do_write(B3 + offs64[i], 2'd0, 1'b1, 1'b1);
    end
    do_write(B2 + 32'h88, 2'd1, 1'b1, 1'b0);          // R6 half-word
    do_write(B3 + 32'h88, 2'd2, 1'b0, 1'b0);          // R6 word
    do_write(B2 - 32'd1, 2'd0, 1'b0, 1'b0);           // R6 just below
    do_write(32'hFF98_0000, 2'd0, 1'b1, 1'b0);        // R6 just above

    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      logic [1:0]  sz;
      int pick;
      pick = $urandom % 10;
      if (pick < 4)      a = (($urandom % 2) ? B3 : B2) + offs32[$urandom % 6];
      else if (pick < 6) a = (($urandom % 2) ? B3 : B2) + offs64[$urandom % 3];
      else if (pick < 9) a = B2 + ($urandom % 32'h80000);
      else               a = $urandom;
      sz = ($urandom % 4 == 0) ? 2'($urandom % 4) : 2'd0;
      do_write(a, sz, 1'($urandom % 2), 1'($urandom % 2));
    end

    // dummy refresh sequence: R8, R9
    do_write(B2, 2'd0, 1'b0, 1'b0);
    chk("R9 cleared by precharge", {31'd0, dummy_ref_done}, 32'd0);
    ref_fast = 1'b1; ref_en = 1'b1;
    k = 0; last = 0; cyc = 0;
    while (k < 9 && cyc < 500) begin
      @(negedge clk); cyc++;
      if (sd_cs_n == 2'b00) begin
        k++;
        chk("R8 refresh encode", {29'd0, sd_ras_n, sd_cas_n, sd_we_n}, 32'd1);
        if (k >= 2) chk("R8 fast interval", cyc - last, RFAST);
        if (k == 7) chk("R9 flag after 7", {31'd0, dummy_ref_done}, 32'd0);
        if (k == 8) chk("R9 flag after 8", {31'd0, dummy_ref_done}, 32'd1);
        last = cyc;
      end
    end
    chk("R8 refresh count", k, 9);
    ref_fast = 1'b0;
    k = 0; cyc = 0;
    while (k < 3 && cyc < 500) begin
      @(negedge clk); cyc++;
      if (sd_cs_n == 2'b00) begin
        k++;
        if (k == 3) chk("R8 normal interval", cyc - last, RNORM);
        last = cyc;
      end
    end
    ref_en = 1'b0;
    repeat (RNORM) @(negedge clk);
    chk("R9 flag held", {31'd0, dummy_ref_done}, 32'd1);
    do_write(B3 + 32'h10, 2'd0, 1'b0, 1'b0);
    chk("R9 cleared again", {31'd0, dummy_ref_done}, 32'd0);
    do_write(B3 + 32'hCC, 2'd0, 1'b1, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule